// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt events from up to sixteen peripheral sources into a pending-status register and gates them with an enable-mask register. It drives a single interrupt request to the CPU. Each source raises its pending bit with a one-cycle set pulse. The bit then stays set until software acknowledges it. The DMA controller's interrupt has its own set input, which feeds pending bit 3.

Software reaches both registers through a simple register port: one write strobe, an address, write data and combinational read data. An acknowledge is a write to the status register. The written value is ANDed into the pending bits, so a 0 clears its bit and a 1 leaves its bit as it was. Writing to the mask register stores the value. The request output is high whenever a pending bit is also enabled. A source that was pending while masked therefore raises the request as soon as its mask bit is turned on.

Top module: `irq_stat_mask_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status register and the mask register both read 0 and `irq_req` is low.
- R2: A 1 on bit i of `src_set` at a clock edge sets status bit i. The bit stays set until software clears it.
- R3: A write to the status offset 0x1070 loads (old status AND `wdata[15:0]`). A 0 in a data bit clears that bit, a 1 keeps it, and no status bit can be set by a write.
- R4: A write to the mask offset 0x1074 stores `wdata[15:0]` in the mask register.
- R5: `irq_req` is high exactly when (status AND mask) is nonzero. It follows every register update in the cycle after the clock edge that makes the update.
- R6: A mask write that enables a bit that is already pending raises `irq_req` in the cycle after that write. The pending bit is not lost while it is masked.
- R7: When a set pulse on bit i and a status write with data bit i at 0 arrive at the same edge, bit i ends up set.
- R8: A read at 0x1070 or 0x1074 returns that register zero-extended to 32 bits. A read at any other address returns 0.
- R9: A write to any address other than 0x1070 or 0x1074 leaves both registers unchanged.
- R10: A pulse on `dma_set` sets status bit 3, with the same behaviour as bit 3 of `src_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 16 | Register address for reads and writes |
| wdata | input | 32 | Write data; only bits 15:0 are used |
| rdata | output | 32 | Read data for `addr`, zero-extended |
| src_set | input | 16 | Per-source set pulses, one bit per status bit |
| dma_set | input | 1 | DMA interrupt set pulse, drives status bit 3 |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
The acknowledge path is driven with single-bit zeros, all-ones words and random words. A bench that only tests writing 0 to one bit cannot tell AND-in behaviour apart from a plain load. The all-ones and random words show that a write never sets a bit. Set pulses are placed on the same edge as a clearing write, at random and on purpose, to separate "set wins" from "clear wins". Mask writes are made both before and after a source goes pending, which shows that the request depends on the stored pending bit and not only on the pulse. Random writes to neighbouring addresses and reads there confirm the decode boundaries.

// File: rtl/irq_pkg.sv
// Package: irq_pkg
// Shared register offsets and the register-select type for the
// interrupt status/mask controller. Assumes a 16-bit address space.
package irq_pkg;
    localparam int unsigned IRQ_ADDR_W   = 16;
    localparam int unsigned IRQ_DATA_W   = 32;
    localparam int unsigned IRQ_N_SRC    = 16;
    localparam int unsigned IRQ_DMA_BIT  = 3;
    localparam logic [IRQ_ADDR_W-1:0] IRQ_STAT_OFS = 16'h1070;
    localparam logic [IRQ_ADDR_W-1:0] IRQ_MASK_OFS = 16'h1074;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/irq_addr_dec.sv
// Module: irq_addr_dec
// Decodes the register address into a register select and write strobes.
// Assumes exactly two mapped offsets; everything else selects nothing.
module irq_addr_dec
    import irq_pkg::*;
#(
    parameter int unsigned ADDR_W = IRQ_ADDR_W,
    parameter logic [ADDR_W-1:0] STAT_OFS = IRQ_STAT_OFS,
    parameter logic [ADDR_W-1:0] MASK_OFS = IRQ_MASK_OFS
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              wr_stat,
    output logic              wr_mask
);
    // Select the addressed register from an exact offset match.
    always_comb begin
        if (addr == STAT_OFS)      sel = SEL_STAT;
        else if (addr == MASK_OFS) sel = SEL_MASK;
        else                       sel = SEL_NONE;
    end

    // Qualify the write strobe per register.
    always_comb begin
        wr_stat = wr_en && (sel == SEL_STAT);
        wr_mask = wr_en && (sel == SEL_MASK);
    end
endmodule

// File: rtl/irq_pend_bank.sv
// Module: irq_pend_bank
// One sticky pending flop per source. A set pulse sets the bit. A status
// write ANDs the write data in. On a collision the set pulse wins.
// Assumes set pulses are already synchronous to clk.
module irq_pend_bank #(
    parameter int unsigned N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stat,
    input  logic [N_SRC-1:0] ack_word,
    input  logic [N_SRC-1:0] set_vec,
    output logic [N_SRC-1:0] pend
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        logic keep;

        // A bit survives unless a status write carries a 0 in its position.
        always_comb keep = !(wr_stat && !ack_word[i]);

        // Pending flop: reset to 0, set dominates acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n) pend[i] <= 1'b0;
            else        pend[i] <= set_vec[i] | (pend[i] & keep);
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Module: irq_mask_reg
// Enable-mask storage, loaded whole on a mask write. Assumes the caller
// has already narrowed the write data to N_SRC bits.
module irq_mask_reg #(
    parameter int unsigned N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mask,
    input  logic [N_SRC-1:0] wdata,
    output logic [N_SRC-1:0] mask
);
    // Mask register: cleared on reset, loaded on a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (wr_mask) mask <= wdata;
    end
endmodule

// File: rtl/irq_req_gen.sv
// Module: irq_req_gen
// Forms the CPU request from the registered pending and mask bits. It is
// combinational from the flops, so the output follows each update with
// no added delay.
module irq_req_gen #(
    parameter int unsigned N_SRC = 16
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] mask,
    output logic             irq_req
);
    // Request when any enabled bit is pending.
    always_comb irq_req = |(pend & mask);
endmodule

// File: rtl/irq_stat_mask_ctrl.sv
// Module: irq_stat_mask_ctrl
// Top of the interrupt status/mask controller. It merges the DMA set
// input into its status bit, decodes register accesses, holds the
// pending and mask registers and drives the request line. Reads are
// combinational and zero-extended. Assumes DATA_W > N_SRC.
module irq_stat_mask_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned ADDR_W  = IRQ_ADDR_W,
    parameter int unsigned DATA_W  = IRQ_DATA_W,
    parameter int unsigned N_SRC   = IRQ_N_SRC,
    parameter int unsigned DMA_BIT = IRQ_DMA_BIT,
    parameter logic [ADDR_W-1:0] STAT_OFS = IRQ_STAT_OFS,
    parameter logic [ADDR_W-1:0] MASK_OFS = IRQ_MASK_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_SRC-1:0]  src_set,
    input  logic              dma_set,
    output logic              irq_req
);
    localparam int unsigned PAD_W = DATA_W - N_SRC;

    reg_sel_e         sel;
    logic             wr_stat;
    logic             wr_mask;
    logic [N_SRC-1:0] set_vec;
    logic [N_SRC-1:0] stat_q;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] wdata_lo;
    logic             unused_wdata_hi;

    // Keep only the meaningful low bits of the write data.
    always_comb wdata_lo = wdata[N_SRC-1:0];
    always_comb unused_wdata_hi = ^wdata[DATA_W-1:N_SRC];

    // Merge the DMA set input into its dedicated status bit.
    for (genvar i = 0; i < N_SRC; i++) begin : g_set
        if (i == DMA_BIT) begin : g_dma
            always_comb set_vec[i] = src_set[i] | dma_set;
        end else begin : g_plain
            always_comb set_vec[i] = src_set[i];
        end
    end

    irq_addr_dec #(
        .ADDR_W   (ADDR_W),
        .STAT_OFS (STAT_OFS),
        .MASK_OFS (MASK_OFS)
    ) u_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .sel     (sel),
        .wr_stat (wr_stat),
        .wr_mask (wr_mask)
    );

    irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stat  (wr_stat),
        .ack_word (wdata_lo),
        .set_vec  (set_vec),
        .pend     (stat_q)
    );

    irq_mask_reg #(.N_SRC(N_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wdata   (wdata_lo),
        .mask    (mask_q)
    );

    irq_req_gen #(.N_SRC(N_SRC)) u_req (
        .pend    (stat_q),
        .mask    (mask_q),
        .irq_req (irq_req)
    );

    // Read mux: the selected register zero-extended, 0 when unmapped.
    always_comb begin
        case (sel)
            SEL_STAT: rdata = {{PAD_W{1'b0}}, stat_q};
            SEL_MASK: rdata = {{PAD_W{1'b0}}, mask_q};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
// Module: irq_ctrl_chk
// Assertion checker for irq_stat_mask_ctrl, attached with bind. It watches
// the ports and the two register outputs of the top.
module irq_ctrl_chk #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned N_SRC   = 16,
    parameter int unsigned DMA_BIT = 3,
    parameter logic [ADDR_W-1:0] STAT_OFS = 16'h1070,
    parameter logic [ADDR_W-1:0] MASK_OFS = 16'h1074
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [N_SRC-1:0]  src_set,
    input logic              dma_set,
    input logic              irq_req,
    input logic [N_SRC-1:0]  stat_q,
    input logic [N_SRC-1:0]  mask_q
);
    logic [N_SRC-1:0] all_set;
    logic             is_stat;
    logic             is_mask;

    // Expected set vector, rebuilt independently from the ports.
    always_comb begin
        all_set = src_set;
        all_set[DMA_BIT] = src_set[DMA_BIT] | dma_set;
        is_stat = (addr == STAT_OFS);
        is_mask = (addr == MASK_OFS);
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|all_set) |=> ((stat_q & $past(all_set)) == $past(all_set))); // R2

    AST_ACK_ANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_stat && all_set == '0)
        |=> (stat_q == ($past(stat_q) & $past(wdata[N_SRC-1:0])))); // R3

    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_mask) |=> (mask_q == $past(wdata[N_SRC-1:0]))); // R4

    AST_UNMASK_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_mask && ((stat_q & wdata[N_SRC-1:0]) != '0)) |=> irq_req); // R6

    AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_stat && ((all_set & ~wdata[N_SRC-1:0]) != '0))
        |=> ((stat_q & $past(all_set)) == $past(all_set))); // R7

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_stat && !is_mask) |-> (rdata == '0)); // R8

    AST_STRAY_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !is_stat && !is_mask && all_set == '0)
        |=> (stat_q == $past(stat_q) && mask_q == $past(mask_q))); // R9
endmodule

bind irq_stat_mask_ctrl irq_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .N_SRC    (N_SRC),
    .DMA_BIT  (DMA_BIT),
    .STAT_OFS (STAT_OFS),
    .MASK_OFS (MASK_OFS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .src_set (src_set),
    .dma_set (dma_set),
    .irq_req (irq_req),
    .stat_q  (stat_q),
    .mask_q  (mask_q)
);

// File: tb/sim_irq_stat_mask_ctrl.sv
// Bench for irq_stat_mask_ctrl: directed corner cases followed by seeded
// random traffic, checked against a reference model kept in the bench.
module sim_irq_stat_mask_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_STAT = 16'h1070;
    localparam logic [15:0] A_MASK = 16'h1074;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = 16'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic [15:0] src_set = 16'h0;
    logic        dma_set = 1'b0;
    logic        irq_req;

    logic [15:0] m_stat = 16'h0;
    logic [15:0] m_mask = 16'h0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_stat_mask_ctrl u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .src_set (src_set),
        .dma_set (dma_set),
        .irq_req (irq_req)
    );

    function automatic logic [15:0] f_stat(logic [15:0] s, logic w, logic [15:0] a,
                                           logic [31:0] d, logic [15:0] set, logic dma);
        logic [15:0] n;
        n = (w && a == A_STAT) ? (s & d[15:0]) : s;   // R3 and R9
        return n | set | (dma ? 16'h0008 : 16'h0);    // R2, R7, R10
    endfunction

    function automatic logic [15:0] f_mask(logic [15:0] m, logic w, logic [15:0] a,
                                           logic [31:0] d);
        return (w && a == A_MASK) ? d[15:0] : m;      // R4 and R9
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Read both registers and the request through the ports (R5, R8).
    task automatic check_regs(string tag);
        addr = A_STAT; #1;
        chk({tag, " stat"}, rdata, {16'h0, m_stat});
        addr = A_MASK; #1;
        chk({tag, " mask"}, rdata, {16'h0, m_mask});
        chk({tag, " R5 irq"}, {31'h0, irq_req}, {31'h0, |(m_stat & m_mask)});
    endtask

    // One clock of stimulus, with the model updated at the edge.
    task automatic step(logic w, logic [15:0] a, logic [31:0] d,
                        logic [15:0] set, logic dma, string tag);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; src_set = set; dma_set = dma;
        @(posedge clk);
        m_stat = f_stat(m_stat, w, a, d, set, dma);
        m_mask = f_mask(m_mask, w, a, d);
        #1;
        wr_en = 1'b0; src_set = 16'h0; dma_set = 1'b0;
        check_regs(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1070));
        repeat (3) @(posedge clk);
        #1;
        check_regs("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, A_STAT, 32'h0, 16'h0, 1'b0, "R1 idle");

        step(1'b0, A_STAT, 32'h0, 16'h0020, 1'b0, "R2 set bit5");
        step(1'b0, A_STAT, 32'h0, 16'h0, 1'b0, "R2 bit5 sticky");
        step(1'b1, A_STAT, 32'hFFFF_FFFF, 16'h0, 1'b0, "R3 all ones keeps");
        step(1'b1, A_STAT, 32'h0000_FFDF, 16'h0, 1'b0, "R3 ack bit5");
        step(1'b1, A_STAT, 32'h0000_FFFF, 16'h0, 1'b0, "R3 write cannot set");

        step(1'b1, A_MASK, 32'hABCD_1234, 16'h0, 1'b0, "R4 mask load");
        step(1'b1, A_MASK, 32'h0, 16'h0, 1'b0, "R4 mask clear");

        step(1'b0, A_STAT, 32'h0, 16'h0400, 1'b0, "R6 pend while masked");
        step(1'b1, A_MASK, 32'h0000_0400, 16'h0, 1'b0, "R6 unmask fires");
        chk("R6 irq high", {31'h0, irq_req}, 32'h1);

        step(1'b1, A_STAT, 32'h0000_FBFF, 16'h0400, 1'b0, "R7 set beats ack");
        chk("R7 bit10 kept", {16'h0, m_stat & 16'h0400}, 32'h0000_0400);

        addr = 16'h1078; #1;
        chk("R8 unmapped read", rdata, 32'h0);
        addr = 16'h1072; #1;
        chk("R8 unmapped mid read", rdata, 32'h0);

        step(1'b1, 16'h1078, 32'h0, 16'h0, 1'b0, "R9 stray write");
        step(1'b1, 16'h1071, 32'hFFFF_FFFF, 16'h0, 1'b0, "R9 stray near stat");

        step(1'b1, A_STAT, 32'h0, 16'h0, 1'b0, "R3 clear all");
        step(1'b1, A_MASK, 32'h0000_0008, 16'h0, 1'b0, "R10 mask dma");
        step(1'b0, A_STAT, 32'h0, 16'h0, 1'b1, "R10 dma sets bit3");
        chk("R10 irq", {31'h0, irq_req}, 32'h1);

        for (int k = 0; k < 2000; k++) begin
            logic [15:0] a;
            logic [15:0] s;
            int pick;
            pick = int'($urandom_range(0, 9));
            a = (pick < 4) ? A_STAT : (pick < 7) ? A_MASK :
                (pick == 7) ? 16'h1078 : 16'($urandom);
            s = ($urandom_range(0, 3) == 0) ? (16'h1 << $urandom_range(0, 15)) : 16'h0;
            step(1'($urandom_range(0, 1)), a, $urandom, s,
                 ($urandom_range(0, 7) == 0), "R2 R3 R4 R7 R9 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule